// File: doc/BRIEF.md
# Pseudo-Random Memory Self-Test Sequencer

This block runs a full write-then-verify pass over a word-addressed memory on its own, with no processor in the loop. A start pulse launches a test in one of two address orders. In linear order the word offsets count upward from zero. In scrambled order the offsets come from a maximal-length shift register that is kicked out of the all-zero state. The engine first stores a pseudo-random data word in every location. It then revisits the locations in the same order and compares each word it reads with a value that a second, identically seeded data generator produces.

The memory is reached through a single request port with a ready handshake. A request, with its address, direction and write data, stays asserted and unchanged until ready is seen, so any number of wait states is accepted. Read data is taken in the cycle where ready is high. The engine stops at the first word that does not match, and it reports the offset and the word it read. In scrambled order a pass also requires that the address walk has returned to its kick value after the last read.

Widths, seeds, feedback taps and the kick value are parameters. The defaults describe a memory of 2^24 words of 32 bits.

Top module: `mem_selftest`

## Requirements
- R1: After reset, and until a start pulse is accepted, busy, done, pass, fail and mem_req are all 0.
- R2: Data words come from a 32-bit shift register seeded with 0xCCAA5533 at start. Each step shifts it left by one and sets the new bit 0 to the XOR of old bits 31, 30, 29 and 9. The register steps before each word is used, so the first word written is the successor of the seed. Word k is the k-th successor.
- R3: With mode = 0 (linear), the write phase and the read phase each visit offsets 0, 1, 2 … 2^ADDR_W−1, in that order.
- R4: With mode = 1 (scrambled), both phases start at offset 0. From offset 0 the next offset is the kick value. From any other offset the next is the left shift of the offset, with new bit 0 equal to the XOR of the parameterised tap bits (bits 23, 22, 21 and 16 at the default width), kept to ADDR_W bits.
- R5: Every location is written (mem_we = 1) before the first read (mem_we = 0). The phase_rd output is 0 during writes and 1 during reads.
- R6: When every read matches, done pulses high for exactly one cycle, in the cycle after the last read is accepted. At the same time pass becomes 1 and fail 0. Both stay until the next accepted start.
- R7: On the first read whose data differs from the regenerated expected word, the engine issues no further requests. One cycle later it raises done and fail. fail_addr then holds that offset and fail_data holds the word that was read.
- R8: While mem_req is high and mem_ready is low, mem_req, mem_we, mem_addr and mem_wdata hold their values into the next cycle.
- R9: A start pulse that arrives while busy is 1 is ignored. The running test and its address order carry on unchanged.
- R10: In scrambled mode, pass is given only if the address walk has returned to the kick value after exactly 2^ADDR_W reads. A test therefore passes after exactly 2·2^ADDR_W accepted transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches a test when idle |
| mode | input | 1 | Address order sampled at start: 0 linear, 1 scrambled |
| mem_req | output | 1 | Memory request, held until mem_ready |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Word offset |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Memory accepts the request in this cycle |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Last test passed |
| fail | output | 1 | Last test failed |
| phase_rd | output | 1 | 0 in the write phase, 1 in the read phase |
| fail_addr | output | ADDR_W | Offset of the first mismatching read |
| fail_data | output | DATA_W | Word read at the first mismatch |

## Verification
Each request's address, direction and write data are due in the same cycle it is accepted. The bench samples the port one nanosecond before every rising edge, and a scoreboard compares each accepted transfer with the next item of a queue built from R2 to R4. done, pass and fail are due exactly one cycle after the final accepted read, or after the mismatching read. The bench records the cycle number of the last transfer and requires done to appear at that number plus one. For a failing run, the bench also checks after a few idle cycles that no further request was issued.

// File: rtl/mst_pkg.sv
package mst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } mst_state_t;
endpackage

// File: rtl/mst_lfsr_next.sv
// Combinational successor of a left-shifting Fibonacci register.
module mst_lfsr_next #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic fb;
  always_comb begin
    fb  = ^(cur & TAPS);
    nxt = {cur[W-2:0], fb};
  end
endmodule

// File: rtl/mst_data_src.sv
// Seeded data generator; exposes the value it will take on its next step.
module mst_data_src #(
  parameter int              DATA_W = 32,
  parameter logic [DATA_W-1:0] TAPS = 32'hE000_0200,
  parameter logic [DATA_W-1:0] SEED = 32'hCCAA_5533
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] cur_q, cur_d;

  mst_lfsr_next #(.W(DATA_W), .TAPS(TAPS)) step_i (.cur(cur_q), .nxt(word));

  always_comb begin
    cur_d = cur_q;
    if (load)     cur_d = SEED;
    else if (adv) cur_d = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cur_q <= SEED;
    else if (load | adv) cur_q <= cur_d;
  end
endmodule

// File: rtl/mst_addr_seq.sv
// Offset walker: linear count or kicked shift-register walk.
module mst_addr_seq #(
  parameter int              ADDR_W = 24,
  parameter logic [ADDR_W-1:0] TAPS = 24'hE1_0000,
  parameter logic [ADDR_W-1:0] KICK = 24'hDE_C0DE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic              rand_mode,
  output logic [ADDR_W-1:0] off,
  output logic [ADDR_W-1:0] off_next
);
  logic [ADDR_W-1:0] off_q;
  logic [ADDR_W-1:0] shifted;

  mst_lfsr_next #(.W(ADDR_W), .TAPS(TAPS)) step_i (.cur(off_q), .nxt(shifted));

  always_comb begin
    if (!rand_mode)      off_next = off_q + 1'b1;
    else if (off_q == '0) off_next = KICK;
    else                 off_next = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    off_q <= '0;
    else if (clr)  off_q <= '0;
    else if (step) off_q <= off_next;
  end

  assign off = off_q;
endmodule

// File: rtl/mst_ctrl.sv
// Phase sequencer, word counter and result capture.
module mst_ctrl
  import mst_pkg::*;
#(
  parameter int              ADDR_W = 24,
  parameter int              DATA_W = 32,
  parameter logic [ADDR_W-1:0] KICK = 24'hDE_C0DE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_in,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] exp_word,
  input  logic [ADDR_W-1:0] cur_off,
  input  logic [ADDR_W-1:0] nxt_off,
  output logic              req,
  output logic              we,
  output logic              wr_adv,
  output logic              rd_adv,
  output logic              src_load,
  output logic              off_clr,
  output logic              off_step,
  output logic              rand_mode,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              phase_rd,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_data
);
  mst_state_t st_q, st_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic rand_q, rand_d;
  logic done_d, pass_d, fail_d;
  logic cap_en;
  logic xfer, last_word, mismatch;

  assign xfer      = req & mem_ready;
  assign last_word = &cnt_q;
  assign mismatch  = rdata != exp_word;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    rand_d   = rand_q;
    done_d   = 1'b0;
    pass_d   = pass;
    fail_d   = fail;
    cap_en   = 1'b0;
    src_load = 1'b0;
    off_clr  = 1'b0;
    off_step = 1'b0;
    wr_adv   = 1'b0;
    rd_adv   = 1'b0;
    req      = (st_q != ST_IDLE);
    we       = (st_q == ST_WRITE);
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d     = ST_WRITE;
          rand_d   = mode_in;
          cnt_d    = '0;
          pass_d   = 1'b0;
          fail_d   = 1'b0;
          src_load = 1'b1;
          off_clr  = 1'b1;
        end
      end
      ST_WRITE: begin
        if (xfer) begin
          wr_adv = 1'b1;
          cnt_d  = cnt_q + 1'b1;
          if (last_word) begin
            st_d    = ST_READ;
            off_clr = 1'b1;
          end else begin
            off_step = 1'b1;
          end
        end
      end
      ST_READ: begin
        if (xfer) begin
          if (mismatch) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            fail_d = 1'b1;
            cap_en = 1'b1;
          end else begin
            rd_adv   = 1'b1;
            off_step = 1'b1;
            cnt_d    = cnt_q + 1'b1;
            if (last_word) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
              if (!rand_q || nxt_off == KICK) pass_d = 1'b1;
              else                            fail_d = 1'b1;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rand_q <= 1'b0;
      done   <= 1'b0;
      pass   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rand_q <= rand_d;
      done   <= done_d;
      pass   <= pass_d;
      fail   <= fail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_addr <= '0;
      fail_data <= '0;
    end else if (cap_en) begin
      fail_addr <= cur_off;
      fail_data <= rdata;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign phase_rd  = (st_q == ST_READ);
  assign rand_mode = rand_q;
endmodule

// File: rtl/mem_selftest.sv
module mem_selftest #(
  parameter int              ADDR_W     = 24,
  parameter int              DATA_W     = 32,
  parameter logic [DATA_W-1:0] DATA_TAPS = 32'hE000_0200,
  parameter logic [DATA_W-1:0] DATA_SEED = 32'hCCAA_5533,
  parameter logic [ADDR_W-1:0] ADDR_TAPS = 24'hE1_0000,
  parameter logic [ADDR_W-1:0] ADDR_KICK = 24'hDE_C0DE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              phase_rd,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_data
);
  localparam int NSRC = 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              src_load, wr_adv, rd_adv;
  logic              off_clr, off_step, rand_mode;
  logic [ADDR_W-1:0] cur_off, nxt_off;
  logic [DATA_W-1:0] src_word [NSRC];
  logic [NSRC-1:0]   src_adv;

  assign src_adv = {rd_adv, wr_adv};

  // index 0 feeds the write phase, index 1 regenerates expected words
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    mst_data_src #(.DATA_W(DATA_W), .TAPS(DATA_TAPS), .SEED(DATA_SEED)) src_i (
      .clk  (clk),
      .rst_n(rst_int_n),
      .load (src_load),
      .adv  (src_adv[g]),
      .word (src_word[g])
    );
  end

  mst_addr_seq #(.ADDR_W(ADDR_W), .TAPS(ADDR_TAPS), .KICK(ADDR_KICK)) addr_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (off_clr),
    .step     (off_step),
    .rand_mode(rand_mode),
    .off      (cur_off),
    .off_next (nxt_off)
  );

  mst_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KICK(ADDR_KICK)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .mode_in  (mode),
    .mem_ready(mem_ready),
    .rdata    (mem_rdata),
    .exp_word (src_word[1]),
    .cur_off  (cur_off),
    .nxt_off  (nxt_off),
    .req      (mem_req),
    .we       (mem_we),
    .wr_adv   (wr_adv),
    .rd_adv   (rd_adv),
    .src_load (src_load),
    .off_clr  (off_clr),
    .off_step (off_step),
    .rand_mode(rand_mode),
    .busy     (busy),
    .done     (done),
    .pass     (pass),
    .fail     (fail),
    .phase_rd (phase_rd),
    .fail_addr(fail_addr),
    .fail_data(fail_data)
  );

  assign mem_addr  = cur_off;
  assign mem_wdata = src_word[0];
endmodule

// File: rtl/mst_checker.sv
module mst_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic              phase_rd,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r5_read_phase_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_rd && mem_req) |-> !mem_we);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != fail) && !busy);

  a_r7_fail_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> !mem_req);

  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(mem_req && mem_ready)) |=> busy);
endmodule

bind mem_selftest mst_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .pass     (pass),
  .fail     (fail),
  .phase_rd (phase_rd),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ready(mem_ready),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata)
);

// File: tb/mem_selftest_tb_top.sv
`timescale 1ns/100ps
module mem_selftest_tb_top;
  localparam int          AW   = 8;
  localparam int          DW   = 32;
  localparam int          NW   = 1 << AW;
  localparam logic [AW-1:0] ATAPS = 8'hB8;
  localparam logic [AW-1:0] AKICK = 8'h5A;
  localparam logic [DW-1:0] DSEED = 32'hCCAA_5533;

  logic          clk, rst_n, start, mode;
  logic          mem_req, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          busy, done, pass, fail, phase_rd;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_data;

  mem_selftest #(
    .ADDR_W(AW), .DATA_W(DW), .DATA_TAPS(32'hE000_0200), .DATA_SEED(DSEED),
    .ADDR_TAPS(ATAPS), .ADDR_KICK(AKICK)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .phase_rd(phase_rd),
    .fail_addr(fail_addr), .fail_data(fail_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } item_t;

  item_t         exp_q[$];
  logic [DW-1:0] mem [int unsigned];
  int            n_chk, n_bad, xfers, cyc, last_xfer_cyc;
  bit            stall_en, corrupt_en, sb_on;
  logic [AW-1:0] corrupt_addr;
  localparam logic [DW-1:0] FLIP = 32'h0000_0100;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dnext(input logic [DW-1:0] v);
    return {v[DW-2:0], v[31] ^ v[30] ^ v[29] ^ v[9]};
  endfunction

  function automatic logic [AW-1:0] anext(input logic [AW-1:0] v, input bit rnd);
    if (!rnd) return v + 1'b1;
    if (v == '0) return AKICK;
    return {v[AW-2:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
  endfunction

  // driver side of the scoreboard: expected transfer stream (R2, R3, R4, R5)
  task automatic build(input bit rnd);
    logic [DW-1:0] d;
    logic [AW-1:0] a;
    item_t it;
    exp_q.delete();
    d = DSEED; a = '0;
    for (int i = 0; i < NW; i++) begin
      d = dnext(d);
      it.we = 1'b1; it.addr = a; it.data = d;
      exp_q.push_back(it);
      a = anext(a, rnd);
    end
    a = '0;
    for (int i = 0; i < NW; i++) begin
      it.we = 1'b0; it.addr = a; it.data = '0;
      exp_q.push_back(it);
      a = anext(a, rnd);
    end
  endtask

  // memory model and monitor side of the scoreboard
  initial begin
    mem_ready = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
      mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : '0;
      if (corrupt_en && mem_addr == corrupt_addr) mem_rdata = mem_rdata ^ FLIP;
      #1;
      if (rst_n && mem_req && mem_ready) begin
        item_t it;
        xfers++;
        last_xfer_cyc = cyc;
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
        if (sb_on) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R5", "unexpected transfer", {56'd0, mem_addr}, 64'd0);
          end else begin
            it = exp_q.pop_front();
            check(mem_we == it.we, "R5", "direction", {63'd0, mem_we}, {63'd0, it.we});
            check(mem_addr == it.addr, it.we ? "R3/R4 write" : "R3/R4 read",
                  "address", {56'd0, mem_addr}, {56'd0, it.addr});
            if (it.we)
              check(mem_wdata == it.data, "R2", "write data",
                    {32'd0, mem_wdata}, {32'd0, it.data});
            check(phase_rd == !it.we, "R5", "phase flag", {63'd0, phase_rd}, {63'd0, !it.we});
          end
        end
      end
    end
  end

  task automatic pulse_start(input bit m);
    @(negedge clk);
    start = 1'b1; mode = m;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int done_cyc, output bit timed_out);
    int guard;
    guard = 0;
    timed_out = 1'b0;
    done_cyc = 0;
    forever begin
      @(negedge clk); #1.5;
      if (done) begin done_cyc = cyc; break; end
      guard++;
      if (guard > 20000) begin timed_out = 1'b1; break; end
    end
    if (timed_out) check(1'b0, "R6", "watchdog expired", 64'd0, 64'd1);
  endtask

  task automatic run_clean(input bit rnd, input bit mid_start);
    int dc; bit to;
    build(rnd);
    xfers = 0;
    pulse_start(rnd);
    if (mid_start) begin
      repeat (40) @(negedge clk);
      start = 1'b1; mode = !rnd;
      @(negedge clk);
      start = 1'b0;
      #1.5;
      check(busy == 1'b1, "R9", "busy after ignored start", {63'd0, busy}, 64'd1);
    end
    wait_done(dc, to);
    if (!to) begin
      check(pass && !fail, "R6", "pass verdict", {62'd0, pass, fail}, 64'h2);
      check(dc == last_xfer_cyc + 1, "R6", "done latency", dc, last_xfer_cyc + 1);
      check(exp_q.size() == 0, "R5", "all transfers seen", exp_q.size(), 0);
      if (rnd)
        check(xfers == 2 * NW, "R10", "transfer count", xfers, 2 * NW);
      @(negedge clk); #1.5;
      check(!done && pass, "R6", "done pulse one cycle, pass held",
            {62'd0, done, pass}, 64'h1);
    end
  endtask

  task automatic run_corrupt(input bit rnd, input logic [AW-1:0] bad);
    int dc, seen; bit to;
    logic [DW-1:0] stored;
    build(rnd);
    corrupt_addr = bad;
    corrupt_en = 1'b1;
    xfers = 0;
    pulse_start(rnd);
    wait_done(dc, to);
    if (!to) begin
      stored = mem[int'(bad)];
      check(fail && !pass, "R7", "fail verdict", {62'd0, pass, fail}, 64'h1);
      check(fail_addr == bad, "R7", "fail_addr", {56'd0, fail_addr}, {56'd0, bad});
      check(fail_data == (stored ^ FLIP), "R7", "fail_data",
            {32'd0, fail_data}, {32'd0, stored ^ FLIP});
      check(dc == last_xfer_cyc + 1, "R7", "done latency", dc, last_xfer_cyc + 1);
      seen = xfers;
      repeat (6) @(negedge clk);
      #1.5;
      check(!mem_req && xfers == seen, "R7", "no request after mismatch",
            {63'd0, mem_req}, 64'd0);
    end
    corrupt_en = 1'b0;
    exp_q.delete();
  endtask

  initial begin
    n_chk = 0; n_bad = 0; xfers = 0; cyc = 0; last_xfer_cyc = 0;
    stall_en = 1'b0; corrupt_en = 1'b0; sb_on = 1'b1; corrupt_addr = '0;
    rst_n = 1'b0; start = 1'b0; mode = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1.5;
    check(!busy && !done && !pass && !fail && !mem_req, "R1", "reset outputs",
          {59'd0, busy, done, pass, fail, mem_req}, 64'd0);

    run_clean(1'b0, 1'b0);          // linear, no stalls
    stall_en = 1'b1;
    run_clean(1'b1, 1'b1);          // scrambled, stalls, ignored start
    run_clean(1'b0, 1'b0);          // linear with stalls
    run_corrupt(1'b0, 8'h37);       // linear, single flipped word
    run_corrupt(1'b1, 8'hA3);       // scrambled, single flipped word
    run_clean(1'b1, 1'b0);          // clean again after failures

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #700000;
    n_chk++; n_bad++;
    $display("FAIL R6 global watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule